// File: doc/BRIEF.md
# Burst Memory Slave with Address Firewall

This block is a memory target on an AXI bus. It holds a word-wide storage array and serves it through two independent channel engines, one for writes and one for reads. Each engine accepts a single burst at a time and walks through the beat addresses for fixed, incrementing or wrapping bursts. Every response carries the transaction ID of the request that caused it.

A fixed window of byte addresses, set by two parameters, is guarded. The engine decides once per burst, from the start address, whether the burst falls under the guard. A guarded write still takes all of its data beats but changes no storage, and it is answered with a slave-error response. A guarded read still returns every beat, with zero data and a slave-error response on each beat. All other bursts complete with OKAY.

Top module: `axfw_slave`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `awready` and `arready` are 1 and `wready`, `bvalid` and `rvalid` are 0.
- R2: One cycle after an AW handshake, `wready` is 1 and `awready` is 0. One cycle after the final W beat, `bvalid` is 1. `bvalid` stays high until `bready` is seen, and `awready` stays low while `bvalid` is high.
- R3: Bit i of `wstrb` allows byte lane i (`wdata[8i+7:8i]`) of the addressed word to be written. Lanes whose strobe bit is 0 keep their old contents.
- R4: Burst code 1 (INCR) advances the byte address by 4 on each beat, modulo the address space.
- R5: Burst code 0 (FIXED) uses the start address on every beat. The last write beat therefore holds the final value.
- R6: Burst code 2 (WRAP) with a length field of 1, 3, 7 or 15 wraps inside an aligned block of 4×(length+1) bytes. Any other length, and burst code 3, is handled as INCR.
- R7: A read returns exactly length+1 beats. `rlast` is 1 on the final beat only, and `arready` is 1 again in the cycle after that beat.
- R8: `bid` equals the `awid` of the burst, and `rid` equals the `arid` of the burst.
- R9: A write whose start address lies in [PROT_LO, PROT_HI] accepts all of its beats, changes no memory word, and gets `bresp` = 2'b10.
- R10: A read whose start address lies in [PROT_LO, PROT_HI] returns `rdata` = 0 and `rresp` = 2'b10 on every beat.
- R11: A burst whose start address lies outside the window gets response 2'b00 and reaches memory, even when its later beats enter the window.
- R12: Pulling `rst_n` low in the middle of a burst sends both engines back to their idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| awvalid | input | 1 | Write request valid |
| awready | output | 1 | Write request accepted |
| awid | input | ID_W | Write transaction ID |
| awaddr | input | ADDR_W | Write start byte address |
| awlen | input | 8 | Write beats minus one |
| awburst | input | 2 | Write burst code |
| wvalid | input | 1 | Write beat valid |
| wready | output | 1 | Write beat accepted |
| wdata | input | DATA_W | Write beat data |
| wstrb | input | DATA_W/8 | Write byte-lane enables |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response taken |
| bid | output | ID_W | Write response ID |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read request valid |
| arready | output | 1 | Read request accepted |
| arid | input | ID_W | Read transaction ID |
| araddr | input | ADDR_W | Read start byte address |
| arlen | input | 8 | Read beats minus one |
| arburst | input | 2 | Read burst code |
| rvalid | output | 1 | Read beat valid |
| rready | input | 1 | Read beat taken |
| rid | output | ID_W | Read beat ID |
| rdata | output | DATA_W | Read beat data |
| rresp | output | 2 | Read beat response code |
| rlast | output | 1 | Final read beat |

## Verification
The bench builds the block with its defaults: a 12-bit byte address (1024 words of 32 bits) and a guarded window from 0x400 to 0x4FF. Because the address space is this small, incrementing bursts that run past the top of memory and bursts that start below the window and run into it can both be reached with short bursts. A reference copy of memory in the bench can then follow every word. With 4-bit IDs, random traffic covers every ID value, so ID echo is checked across the full range.

// File: rtl/axfw_pkg.sv
package axfw_pkg;

  typedef enum logic [1:0] {
    BT_FIXED = 2'd0,
    BT_INCR  = 2'd1,
    BT_WRAP  = 2'd2,
    BT_RSVD  = 2'd3
  } burst_e;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_DATA = 2'd1,
    WS_RESP = 2'd2
  } wr_state_e;

  typedef enum logic {
    RS_IDLE = 1'b0,
    RS_DATA = 1'b1
  } rd_state_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  // legal wrap lengths: 2, 4, 8 or 16 beats
  function automatic logic wrap_len_ok(input logic [7:0] len);
    return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
  endfunction

  // address of the beat that follows beat address a
  function automatic logic [31:0] beat_next(input logic [31:0] a,
                                            input logic [1:0]  bt,
                                            input logic [7:0]  len,
                                            input int unsigned lsb);
    logic [31:0] step, span, mask, res;
    step = 32'd1 << lsb;
    span = (32'(len) + 32'd1) << lsb;
    mask = span - 32'd1;
    case (burst_e'(bt))
      BT_FIXED: res = a;
      BT_WRAP:  res = wrap_len_ok(len) ? ((a & ~mask) | ((a + step) & mask)) : (a + step);
      default:  res = a + step;
    endcase
    return res;
  endfunction

  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/axfw_mem.sv
module axfw_mem #(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                we,
  input  logic [IDX_W-1:0]    widx,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  input  logic [IDX_W-1:0]    ridx,
  output logic [DATA_W-1:0]   rdata
);
  localparam int WORDS = 1 << IDX_W;
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] store [WORDS];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && wstrb[g]) store[widx][8*g +: 8] <= wdata[8*g +: 8];
    end
  end

  assign rdata = store[ridx];
endmodule

// File: rtl/axfw_wr_ch.sv
module axfw_wr_ch
  import axfw_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          ID_W    = 4,
  parameter int          LSB     = 2,
  parameter logic [31:0] PROT_LO = 32'h400,
  parameter logic [31:0] PROT_HI = 32'h4FF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 awvalid,
  output logic                 awready,
  input  logic [ID_W-1:0]      awid,
  input  logic [ADDR_W-1:0]    awaddr,
  input  logic [7:0]           awlen,
  input  logic [1:0]           awburst,
  input  logic                 wvalid,
  output logic                 wready,
  output logic                 bvalid,
  input  logic                 bready,
  output logic [ID_W-1:0]      bid,
  output logic [1:0]           bresp,
  output logic                 mem_we,
  output logic [ADDR_W-LSB-1:0] mem_idx
);
  wr_state_e         st;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        len_q, cnt_q;
  logic [1:0]        bt_q;
  logic [ID_W-1:0]   id_q;
  logic              blk_q;

  logic aw_fire, w_fire, b_fire, beat_last;
  assign aw_fire   = awvalid && awready;
  assign w_fire    = wvalid && wready;
  assign b_fire    = bvalid && bready;
  assign beat_last = (cnt_q == len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= WS_IDLE;
      addr_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      bt_q   <= '0;
      id_q   <= '0;
      blk_q  <= 1'b0;
    end else begin
      case (st)
        WS_IDLE: if (aw_fire) begin
          addr_q <= awaddr;
          len_q  <= awlen;
          bt_q   <= awburst;
          id_q   <= awid;
          cnt_q  <= '0;
          blk_q  <= in_window(32'(awaddr), PROT_LO, PROT_HI);
          st     <= WS_DATA;
        end
        WS_DATA: if (w_fire) begin
          addr_q <= ADDR_W'(beat_next(32'(addr_q), bt_q, len_q, LSB));
          cnt_q  <= cnt_q + 8'd1;
          if (beat_last) st <= WS_RESP;
        end
        WS_RESP: if (b_fire) st <= WS_IDLE;
        default: st <= WS_IDLE;
      endcase
    end
  end

  assign awready = (st == WS_IDLE);
  assign wready  = (st == WS_DATA);
  assign bvalid  = (st == WS_RESP);
  assign bid     = id_q;
  assign bresp   = blk_q ? RESP_SLVERR : RESP_OKAY;
  assign mem_we  = w_fire && !blk_q;
  assign mem_idx = addr_q[ADDR_W-1:LSB];
endmodule

// File: rtl/axfw_rd_ch.sv
module axfw_rd_ch
  import axfw_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          ID_W    = 4,
  parameter int          DATA_W  = 32,
  parameter int          LSB     = 2,
  parameter logic [31:0] PROT_LO = 32'h400,
  parameter logic [31:0] PROT_HI = 32'h4FF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arvalid,
  output logic                  arready,
  input  logic [ID_W-1:0]       arid,
  input  logic [ADDR_W-1:0]     araddr,
  input  logic [7:0]            arlen,
  input  logic [1:0]            arburst,
  output logic                  rvalid,
  input  logic                  rready,
  output logic [ID_W-1:0]       rid,
  output logic [DATA_W-1:0]     rdata,
  output logic [1:0]            rresp,
  output logic                  rlast,
  output logic [ADDR_W-LSB-1:0] mem_idx,
  input  logic [DATA_W-1:0]     mem_rdata
);
  rd_state_e         st;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        len_q, cnt_q;
  logic [1:0]        bt_q;
  logic [ID_W-1:0]   id_q;
  logic              blk_q;

  logic ar_fire, r_fire, beat_last;
  assign ar_fire   = arvalid && arready;
  assign r_fire    = rvalid && rready;
  assign beat_last = (cnt_q == len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RS_IDLE;
      addr_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      bt_q   <= '0;
      id_q   <= '0;
      blk_q  <= 1'b0;
    end else begin
      case (st)
        RS_IDLE: if (ar_fire) begin
          addr_q <= araddr;
          len_q  <= arlen;
          bt_q   <= arburst;
          id_q   <= arid;
          cnt_q  <= '0;
          blk_q  <= in_window(32'(araddr), PROT_LO, PROT_HI);
          st     <= RS_DATA;
        end
        RS_DATA: if (r_fire) begin
          addr_q <= ADDR_W'(beat_next(32'(addr_q), bt_q, len_q, LSB));
          cnt_q  <= cnt_q + 8'd1;
          if (beat_last) st <= RS_IDLE;
        end
        default: st <= RS_IDLE;
      endcase
    end
  end

  assign arready = (st == RS_IDLE);
  assign rvalid  = (st == RS_DATA);
  assign rid     = id_q;
  assign rlast   = rvalid && beat_last;
  assign rresp   = blk_q ? RESP_SLVERR : RESP_OKAY;
  assign rdata   = blk_q ? '0 : mem_rdata;
  assign mem_idx = addr_q[ADDR_W-1:LSB];
endmodule

// File: rtl/axfw_slave.sv
module axfw_slave #(
  parameter int          ADDR_W  = 12,
  parameter int          ID_W    = 4,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] PROT_LO = 32'h400,
  parameter logic [31:0] PROT_HI = 32'h4FF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                awvalid,
  output logic                awready,
  input  logic [ID_W-1:0]     awid,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic [7:0]          awlen,
  input  logic [1:0]          awburst,
  input  logic                wvalid,
  output logic                wready,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  output logic                bvalid,
  input  logic                bready,
  output logic [ID_W-1:0]     bid,
  output logic [1:0]          bresp,
  input  logic                arvalid,
  output logic                arready,
  input  logic [ID_W-1:0]     arid,
  input  logic [ADDR_W-1:0]   araddr,
  input  logic [7:0]          arlen,
  input  logic [1:0]          arburst,
  output logic                rvalid,
  input  logic                rready,
  output logic [ID_W-1:0]     rid,
  output logic [DATA_W-1:0]   rdata,
  output logic [1:0]          rresp,
  output logic                rlast
);
  localparam int BEAT_B = DATA_W / 8;
  localparam int LSB    = $clog2(BEAT_B);
  localparam int IDX_W  = ADDR_W - LSB;

  logic              mem_we;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] mem_rdata;

  axfw_wr_ch #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .LSB(LSB), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
  ) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .awready(awready), .awid(awid), .awaddr(awaddr),
    .awlen(awlen), .awburst(awburst),
    .wvalid(wvalid), .wready(wready),
    .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
    .mem_we(mem_we), .mem_idx(wr_idx)
  );

  axfw_rd_ch #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W), .LSB(LSB),
    .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
  ) u_rd (
    .clk(clk), .rst_n(rst_n),
    .arvalid(arvalid), .arready(arready), .arid(arid), .araddr(araddr),
    .arlen(arlen), .arburst(arburst),
    .rvalid(rvalid), .rready(rready), .rid(rid), .rdata(rdata),
    .rresp(rresp), .rlast(rlast),
    .mem_idx(rd_idx), .mem_rdata(mem_rdata)
  );

  axfw_mem #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .widx(wr_idx), .wdata(wdata), .wstrb(wstrb),
    .ridx(rd_idx), .rdata(mem_rdata)
  );
endmodule

// File: rtl/axfw_chk.sv
module axfw_chk
  import axfw_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          ID_W    = 4,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] PROT_LO = 32'h400,
  parameter logic [31:0] PROT_HI = 32'h4FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              awvalid,
  input logic              awready,
  input logic [ID_W-1:0]   awid,
  input logic [ADDR_W-1:0] awaddr,
  input logic              bvalid,
  input logic              bready,
  input logic [ID_W-1:0]   bid,
  input logic [1:0]        bresp,
  input logic              arvalid,
  input logic              arready,
  input logic [ID_W-1:0]   arid,
  input logic [ADDR_W-1:0] araddr,
  input logic [7:0]        arlen,
  input logic              rvalid,
  input logic              rready,
  input logic [ID_W-1:0]   rid,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        rresp,
  input logic              rlast,
  input logic              mem_we
);
  logic            w_blk, r_blk;
  logic [ID_W-1:0] w_id, r_id;
  logic [7:0]      r_len;
  logic [8:0]      r_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_blk <= 1'b0; r_blk <= 1'b0; w_id <= '0; r_id <= '0;
      r_len <= '0;   r_beat <= '0;
    end else begin
      if (awvalid && awready) begin
        w_blk <= in_window(32'(awaddr), PROT_LO, PROT_HI);
        w_id  <= awid;
      end
      if (arvalid && arready) begin
        r_blk  <= in_window(32'(araddr), PROT_LO, PROT_HI);
        r_id   <= arid;
        r_len  <= arlen;
        r_beat <= '0;
      end else if (rvalid && rready) begin
        r_beat <= r_beat + 9'd1;
      end
    end
  end

  AST_FW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !w_blk);                                              // R9
  AST_BRESP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (bresp == (w_blk ? 2'b10 : 2'b00)));                  // R11
  AST_BID_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (bid == w_id));                                       // R8
  AST_RID_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rid == r_id));                                       // R8
  AST_RLAST_POS: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rlast == (r_beat == {1'b0, r_len})));                // R7
  AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && r_blk) |-> (rdata == '0 && rresp == 2'b10));          // R10
  AST_AW_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !awready);                                            // R2
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);                                 // R2
endmodule

bind axfw_slave axfw_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .awvalid(awvalid), .awready(awready), .awid(awid), .awaddr(awaddr),
  .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
  .arvalid(arvalid), .arready(arready), .arid(arid), .araddr(araddr), .arlen(arlen),
  .rvalid(rvalid), .rready(rready), .rid(rid), .rdata(rdata), .rresp(rresp),
  .rlast(rlast), .mem_we(mem_we)
);

// File: tb/axfw_slave_tb.sv
`timescale 1ns/1ps
module axfw_slave_tb;
  localparam int LO = 'h400;
  localparam int HI = 'h4FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [3:0]  awid = 0, arid = 0;
  logic [11:0] awaddr = 0, araddr = 0;
  logic [7:0]  awlen = 0, arlen = 0;
  logic [1:0]  awburst = 0, arburst = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  wstrb = 0;
  logic        awready, wready, bvalid, arready, rvalid, rlast;
  logic [3:0]  bid, rid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [0:1023];

  always #4 clk = ~clk;

  axfw_slave u_dut (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .awready(awready), .awid(awid), .awaddr(awaddr),
    .awlen(awlen), .awburst(awburst),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .arid(arid), .araddr(araddr),
    .arlen(arlen), .arburst(arburst),
    .rvalid(rvalid), .rready(rready), .rid(rid), .rdata(rdata),
    .rresp(rresp), .rlast(rlast)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit fw_hit(input int a);
    return (a >= LO) && (a <= HI);
  endfunction

  // next beat address, restated with division and modulo
  function automatic int exp_next(input int a, input int bt, input int len);
    int span, base;
    if (bt == 0) return a;
    if (bt == 2 && (len == 1 || len == 3 || len == 7 || len == 15)) begin
      span = (len + 1) * 4;
      base = (a / span) * span;
      return base + ((a - base + 4) % span);
    end
    return (a + 4) % 4096;
  endfunction

  task automatic do_write(input int id, input int a, input int len, input int bt,
                          input bit rnd_strb, input string req);
    int cur = a;
    bit blk = fw_hit(a);
    logic [31:0] d;
    logic [3:0]  s;
    @(negedge clk);
    awvalid = 1; awid = 4'(id); awaddr = 12'(a); awlen = 8'(len); awburst = 2'(bt);
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 0;
    chk(wready && !awready, "R2", {30'd0, awready, wready}, 32'd1);
    for (int i = 0; i <= len; i++) begin
      d = $urandom;
      s = rnd_strb ? 4'($urandom % 16) : 4'hF;
      wvalid = 1; wdata = d; wstrb = s;
      while (!wready) @(negedge clk);
      @(negedge clk);
      if (!blk)
        for (int b = 0; b < 4; b++)
          if (s[b]) model[cur / 4][8*b +: 8] = d[8*b +: 8];
      cur = exp_next(cur, bt, len);
    end
    wvalid = 0;
    chk(bvalid === 1'b1, "R2", {31'd0, bvalid}, 32'd1);
    for (int k = 0; k < int'($urandom % 3); k++) begin
      @(negedge clk);
      chk(bvalid === 1'b1 && !awready, "R2", {30'd0, bvalid, awready}, 32'd2);
    end
    bready = 1;
    chk(bresp === (blk ? 2'b10 : 2'b00), blk ? "R9" : req, 32'(bresp), blk ? 32'd2 : 32'd0);
    chk(bid === 4'(id), "R8", 32'(bid), 32'(id));
    @(negedge clk);
    bready = 0;
  endtask

  task automatic do_read(input int id, input int a, input int len, input int bt, input string req);
    int cur = a;
    bit blk = fw_hit(a);
    logic [31:0] e;
    @(negedge clk);
    arvalid = 1; arid = 4'(id); araddr = 12'(a); arlen = 8'(len); arburst = 2'(bt);
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 0;
    for (int i = 0; i <= len; i++) begin
      while (!rvalid) @(negedge clk);
      for (int k = 0; k < int'($urandom % 3); k++) @(negedge clk);
      rready = 1;
      e = blk ? 32'd0 : model[cur / 4];
      chk(rvalid === 1'b1, "R7", {31'd0, rvalid}, 32'd1);
      chk(rdata === e, blk ? "R10" : req, rdata, e);
      chk(rresp === (blk ? 2'b10 : 2'b00), blk ? "R10" : "R11", 32'(rresp), blk ? 32'd2 : 32'd0);
      chk(rid === 4'(id), "R8", 32'(rid), 32'(id));
      chk(rlast === (i == len), "R7", {31'd0, rlast}, 32'(i == len));
      @(negedge clk);
      rready = 0;
      cur = exp_next(cur, bt, len);
    end
    chk(arready === 1'b1 && rvalid === 1'b0, "R7", {30'd0, arready, rvalid}, 32'd2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int bt, len, a;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) model[i] = 'x;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(awready && arready && !wready && !bvalid && !rvalid, "R1",
        {27'd0, awready, arready, wready, bvalid, rvalid}, 32'h18);
    rst_n = 1;
    @(negedge clk);
    chk(awready && arready && !wready && !bvalid && !rvalid, "R1",
        {27'd0, awready, arready, wready, bvalid, rvalid}, 32'h18);

    // fill memory; the burst at 0x400 is guarded (R9)
    for (int p = 0; p < 16; p++) do_write(p, p * 256, 63, 1, 0, "R4");
    do_read(1, 'h3F0, 7, 1, "R11");       // R11: crosses into window, not guarded
    do_read(2, 'h400, 3, 1, "R10");       // R10: guarded read
    do_read(3, 'h000, 255, 1, "R4");      // R4: 256-beat INCR

    // R3: strobed writes
    do_write(4, 'h100, 3, 1, 1, "R3");
    do_read(4, 'h100, 3, 1, "R3");
    // R5: fixed burst keeps address
    do_write(5, 'h200, 3, 0, 0, "R5");
    do_read(5, 'h200, 2, 0, "R5");
    do_read(5, 'h1FC, 2, 1, "R5");
    // R6: wrap inside 16-byte block, then invalid length behaves as INCR
    do_write(6, 'h03C, 3, 2, 0, "R6");
    do_read(6, 'h030, 3, 1, "R6");
    do_write(7, 'h0A8, 2, 2, 0, "R6");
    do_read(7, 'h0A0, 5, 1, "R6");
    do_read(7, 'h0B8, 7, 2, "R6");
    // R4: incrementing burst running past the top of memory
    do_write(8, 'hFF8, 3, 1, 0, "R4");
    do_read(8, 'h000, 1, 1, "R4");
    // R11: write starting below window reaches memory inside it
    do_write(9, 'h3F8, 3, 1, 0, "R11");
    do_read(9, 'h3F8, 1, 1, "R11");

    // random traffic
    for (int t = 0; t < 80; t++) begin
      bt  = int'($urandom % 4);
      len = (bt == 2) ? (1 << ($urandom % 5)) - 1 : int'($urandom % 16);
      a   = int'($urandom % 1024) * 4;
      if ($urandom % 2) do_write(t % 16, a, len, bt, 1, "R4");
      else              do_read(t % 16, a, len, bt, "R4");
    end

    // R12: reset in the middle of a guarded write
    @(negedge clk);
    awvalid = 1; awid = 4'hA; awaddr = 12'h480; awlen = 8'd3; awburst = 2'd1;
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 1; wdata = 32'h1; wstrb = 4'hF;
    @(negedge clk);
    wvalid = 0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(awready && !wready && !bvalid && arready && !rvalid, "R12",
        {27'd0, awready, wready, bvalid, arready, rvalid}, 32'h12);
    do_write(11, 'h300, 1, 1, 0, "R12");
    do_read(11, 'h300, 1, 1, "R12");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule